// File: doc/BRIEF.md
# Three-Input Function Majority Classifier

This block takes the truth table of a Boolean function of three inputs and names the symmetry class it falls in. The class is taken from the point set of the function on the three-dimensional binary cube. Two functions share a class when some relabelling of the inputs turns one into the other. A relabelling may permute the inputs, invert any of them, or do both. There are thirteen such classes for point sets of one to four vertices. Larger point sets are folded onto their complements first. For each class the block also reports how many three-input majority gates a reduced realisation of the function needs.

A request is offered with a valid/ready handshake. The block computes the number of set points and complements the table when that count is five, six or seven. It then applies one cube symmetry per clock for 48 clocks and keeps the numerically smallest transformed table. That canonical table is matched against thirteen fixed patterns. The class code, the complement flag and the gate count come out together with a one-cycle done pulse. They stay there until the next result replaces them.

Top module: `cube_class_unit`

## Requirements
- R1: `req_ready` is high whenever no request is in progress. A request is taken on a rising edge that sees both `req_valid` and `req_ready` high. `req_ready` is low from the next cycle until the done cycle, and it is high again in the done cycle. A `req_valid` raised while the block is busy has no effect.
- R2: `done` is high for exactly one cycle. That cycle begins at the 48th rising edge after the accepting edge.
- R3: `res_class`, `res_compl` and `res_gates` change only at the edge that raises `done`. They hold their values in every other cycle.
- R4: Bit i of `req_table` is the function value at the vertex a=i[2], b=i[1], c=i[0]. Permuting a, b and c, or inverting any of them, never changes the reported class.
- R5: With 5, 6 or 7 set bits, `res_compl` is 1 and the class is that of the 3, 2 or 1 clear bits. With 0 to 4 or 8 set bits, `res_compl` is 0.
- R6: Table 8'h00 gives class 0 and table 8'hFF gives class 15, both with gate count 0. Class 14 is never produced.
- R7: Two points give class 2 when they share an edge, class 3 when they are diagonal on one face, and class 4 when they are opposite across the cube.
- R8: One point gives class 1. Three points give class 5 for two edges meeting at a vertex, class 6 for an edge plus a point adjacent to neither end, and class 7 for three pairwise non-adjacent points.
- R9: Four points give class 8 for a face and class 9 for a vertex with its three neighbours. They give class 10 for two opposite parallel edges and class 11 for a two-edge corner plus a point adjacent to none of it. They give class 12 for a three-edge path that leaves every face, and class 13 for the four pairwise non-adjacent points (three-input parity).
- R10: Majority gate counts per class 1..13 are 2, 1, 3, 5, 2, 4, 4, 0, 1, 3, 5, 3, 3.
- R11: While reset is held and just after it ends, `req_ready` is 1, `done` is 0, and all results are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_table | input | 8 | Truth table, bit i for vertex {a,b,c}=i |
| done | output | 1 | One-cycle pulse when results update |
| res_class | output | 4 | Class code: 0 constant zero, 1..13 classes, 15 constant one |
| res_compl | output | 1 | Table was complemented before classification |
| res_gates | output | 3 | Majority gate count of the class |

## Verification
The block has no parameters, so the bench builds its single fixed configuration. In that configuration every one of the 256 tables is reachable, and the bench submits each one. It checks class, complement flag, gate count and latency against values it derives from the vertex geometry: point count, adjacent pairs, opposite pairs and vertex degree. It then checks that the collected classes agree across all 48 cube symmetries of every table. Along the way it issues requests back to back in the done cycle and offers requests while the block is busy.

// File: rtl/cube_class_unit.sv
module cube_class_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_table,
  output logic       done,
  output logic [3:0] res_class,
  output logic       res_compl,
  output logic [2:0] res_gates
);

  localparam logic [2:0] LAST_PERM = 3'd5;
  localparam logic [2:0] LAST_MASK = 3'd7;
  localparam logic [3:0] CODE_ZERO = 4'd0;
  localparam logic [3:0] CODE_ONE  = 4'd15;
  localparam logic [3:0] CODE_BAD  = 4'd14;

  logic       busy;
  logic [7:0] work;
  logic [7:0] best;
  logic [2:0] perm_q;
  logic [2:0] mask_q;
  logic       compl_q;
  logic [3:0] pop;
  logic       fold;
  logic [7:0] cand;
  logic [7:0] cand_min;
  logic       last;
  logic [3:0] cls_n;

  function automatic logic [7:0] apply_sym(input logic [7:0] t,
                                           input logic [2:0] p,
                                           input logic [2:0] m);
    logic [7:0] r;
    logic [2:0] v;
    logic [2:0] s;
    r = '0;
    for (int j = 0; j < 8; j++) begin
      v = 3'(j);
      case (p)
        3'd0:    s = {v[2], v[1], v[0]};
        3'd1:    s = {v[2], v[0], v[1]};
        3'd2:    s = {v[1], v[2], v[0]};
        3'd3:    s = {v[1], v[0], v[2]};
        3'd4:    s = {v[0], v[2], v[1]};
        default: s = {v[0], v[1], v[2]};
      endcase
      r[j] = t[s ^ m];
    end
    return r;
  endfunction

  function automatic logic [3:0] class_of(input logic [7:0] c);
    case (c)
      8'h00:   return CODE_ZERO;
      8'hFF:   return CODE_ONE;
      8'h01:   return 4'd1;
      8'h03:   return 4'd2;
      8'h06:   return 4'd3;
      8'h18:   return 4'd4;
      8'h07:   return 4'd5;
      8'h19:   return 4'd6;
      8'h16:   return 4'd7;
      8'h0F:   return 4'd8;
      8'h17:   return 4'd9;
      8'h3C:   return 4'd10;
      8'h1E:   return 4'd11;
      8'h1B:   return 4'd12;
      8'h69:   return 4'd13;
      default: return CODE_BAD;
    endcase
  endfunction

  function automatic logic [2:0] gates_of(input logic [3:0] k);
    case (k)
      4'd1, 4'd5:                 return 3'd2;
      4'd2, 4'd9:                 return 3'd1;
      4'd3, 4'd10, 4'd12, 4'd13:  return 3'd3;
      4'd4, 4'd11:                return 3'd5;
      4'd6, 4'd7:                 return 3'd4;
      default:                    return 3'd0;
    endcase
  endfunction

  assign req_ready = !busy;
  assign pop       = 4'($countones(req_table));
  assign fold      = (pop >= 4'd5) && (pop <= 4'd7);
  assign cand      = apply_sym(work, perm_q, mask_q);
  assign cand_min  = (cand < best) ? cand : best;
  assign last      = (perm_q == LAST_PERM) && (mask_q == LAST_MASK);
  assign cls_n     = class_of(cand_min);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      work      <= '0;
      best      <= '1;
      perm_q    <= '0;
      mask_q    <= '0;
      compl_q   <= 1'b0;
      done      <= 1'b0;
      res_class <= CODE_ZERO;
      res_compl <= 1'b0;
      res_gates <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          work    <= fold ? ~req_table : req_table;
          compl_q <= fold;
          best    <= '1;
          perm_q  <= '0;
          mask_q  <= '0;
        end
      end else begin
        best <= cand_min;
        if (mask_q == LAST_MASK) begin
          mask_q <= '0;
          perm_q <= perm_q + 3'd1;
        end else begin
          mask_q <= mask_q + 3'd1;
        end
        if (last) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          res_class <= cls_n;
          res_compl <= compl_q;
          res_gates <= gates_of(cls_n);
        end
      end
    end
  end

endmodule

// File: rtl/cube_class_unit_chk.sv
module cube_class_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [3:0] res_class,
  input logic       res_compl,
  input logic [2:0] res_gates
);

  logic       armed;
  logic [5:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      lat   <= '0;
    end else if (req_valid && req_ready) begin
      armed <= 1'b1;
      lat   <= '0;
    end else if (done) begin
      armed <= 1'b0;
    end else if (armed && lat != 6'd63) begin
      lat <= lat + 6'd1;
    end
  end

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_ready_at_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (armed && lat == 6'd48));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_class, res_compl, res_gates}));

  p_compl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_compl |-> (res_class >= 4'd1 && res_class <= 4'd7));

  p_code_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_class != 4'd14);

  p_const_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_class == 4'd0 || res_class == 4'd15) |-> (res_gates == 3'd0 && !res_compl));

endmodule

bind cube_class_unit cube_class_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .res_class(res_class), .res_compl(res_compl), .res_gates(res_gates)
);

// File: tb/cube_class_unit_tb_top.sv
module cube_class_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_table;
  logic       done;
  logic [3:0] res_class;
  logic       res_compl;
  logic [2:0] res_gates;

  int n_checks = 0;
  int n_fail   = 0;
  int cur      = 0;
  int got [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  cube_class_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_table(req_table), .done(done), .res_class(res_class),
    .res_compl(res_compl), .res_gates(res_gates)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s table=%02h actual=%0d expected=%0d", tag, cur, act, exp);
    end
  endtask

  function automatic logic [7:0] xf(input logic [7:0] t, input int p, input int m);
    logic [7:0] r;
    int f, g, h, tmp, s;
    f = p / 2;
    g = (f == 0) ? 1 : 0;
    h = 3 - f - g;
    if (p % 2 == 1) begin tmp = g; g = h; h = tmp; end
    r = '0;
    for (int j = 0; j < 8; j++) begin
      s = (((j >> f) & 1) << 2) | (((j >> g) & 1) << 1) | ((j >> h) & 1);
      s = s ^ m;
      r[j] = t[s];
    end
    return r;
  endfunction

  function automatic int exp_class(input logic [7:0] t);
    logic [7:0] s;
    int k, n, e1, e3, maxdeg, deg;
    k = $countones(t);
    if (k == 0) return 0;
    if (k == 8) return 15;
    s = (k >= 5) ? ~t : t;
    n = $countones(s);
    e1 = 0; e3 = 0; maxdeg = 0;
    for (int i = 0; i < 8; i++) begin
      deg = 0;
      for (int j = 0; j < 8; j++) begin
        if (s[i] && s[j] && i != j) begin
          if ($countones(3'(i ^ j)) == 1) deg++;
          if (i < j && $countones(3'(i ^ j)) == 1) e1++;
          if (i < j && $countones(3'(i ^ j)) == 3) e3++;
        end
      end
      if (deg > maxdeg) maxdeg = deg;
    end
    case (n)
      1: return 1;
      2: return (e1 == 1) ? 2 : (e3 == 1) ? 4 : 3;
      3: return (e1 == 2) ? 5 : (e1 == 1) ? 6 : 7;
      default: begin
        if (e1 == 4) return 8;
        if (e1 == 3) return (maxdeg == 3) ? 9 : 12;
        if (e1 == 0) return 13;
        return (e3 == 2) ? 10 : 11;
      end
    endcase
  endfunction

  function automatic int exp_cost(input int c);
    case (c)
      1: return 2;  2: return 1;  3: return 3;  4: return 5;
      5: return 2;  6: return 4;  7: return 4;  8: return 0;
      9: return 1;  10: return 3; 11: return 5; 12: return 3;
      13: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic string class_tag(input logic [7:0] t);
    int k;
    k = $countones(t);
    if (k == 0 || k == 8) return "R6";
    if (k >= 5) k = 8 - k;
    if (k == 2) return "R7";
    if (k == 4) return "R9";
    return "R8";
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n, ec, k;
    logic [3:0] hold_c;
    logic       hold_x;
    logic [2:0] hold_g;
    bit seen [256];
    int forms;
    logic [7:0] mn, v;

    rst_n = 1'b0; req_valid = 1'b0; req_table = '0;
    repeat (3) @(negedge clk);
    // R11 reset state while reset held
    chk(req_ready == 1'b1 && done == 1'b0, "R11", {req_ready, done}, 2);
    chk(res_class == 0 && res_compl == 0 && res_gates == 0, "R11", res_class, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && res_class == 0, "R11", {req_ready, done}, 2);

    for (int t = 0; t < 256; t++) begin
      cur = t;
      req_valid = 1'b1;
      req_table = 8'(t);
      chk(req_ready == 1'b1, "R1", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R1", req_ready, 0);
      n = 0;
      while (!done && n < 200) begin
        if (t % 4 == 1 && n == 5) begin
          chk(req_ready == 1'b0, "R1", req_ready, 0);
          req_valid = 1'b1;
          req_table = ~8'(t);
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
        n++;
      end
      req_valid = 1'b0;
      chk(n == 48, "R2", n, 48);
      ec = exp_class(8'(t));
      k = $countones(8'(t));
      chk(int'(res_class) == ec, class_tag(8'(t)), res_class, ec);
      chk(res_compl == (k >= 5 && k <= 7), "R5", res_compl, (k >= 5 && k <= 7));
      chk(int'(res_gates) == exp_cost(ec), "R10", res_gates, exp_cost(ec));
      chk(req_ready == 1'b1, "R1", req_ready, 1);
      got[t] = res_class;
      if (t % 2 == 1) begin
        hold_c = res_class; hold_x = res_compl; hold_g = res_gates;
        @(negedge clk);
        chk(done == 1'b0, "R2", done, 0);
        chk(res_class == hold_c && res_compl == hold_x && res_gates == hold_g,
            "R3", res_class, hold_c);
      end
    end

    // R4: class invariant under all 48 cube symmetries
    for (int t = 0; t < 256; t++) begin
      cur = t;
      for (int p = 0; p < 6; p++) begin
        for (int m = 0; m < 8; m++) begin
          v = xf(8'(t), p, m);
          chk(got[t] == got[v], "R4", got[v], got[t]);
        end
      end
    end

    // R4 sanity: 80 permutation-only canonical forms
    forms = 0;
    for (int t = 0; t < 256; t++) seen[t] = 1'b0;
    for (int t = 0; t < 256; t++) begin
      mn = 8'hFF;
      for (int p = 0; p < 6; p++) begin
        v = xf(8'(t), p, 0);
        if (v < mn) mn = v;
      end
      if (!seen[mn]) begin seen[mn] = 1'b1; forms++; end
    end
    cur = 0;
    chk(forms == 80, "R4", forms, 80);

    finish_run();
  end

endmodule